// File: doc/BRIEF.md
# MEI Coherency Line State Controller

This block keeps the coherency state of every line of a write-back data cache under a three-state protocol with Invalid, Exclusive and Modified states. There is no Shared state. Each cycle it can take one processor event, already classified by the tag logic as a read hit, read miss, write hit or write miss. In the same cycle it can take one snooped bus event that has hit a line, classed as either a cacheable read/write or a cache-inhibited read. From these it computes each addressed line's next state and writes it back. The states sit in a small array addressed by a set/way index.

When a processor miss needs data from memory, the block raises a one-cycle fill request that carries the line index. When a snoop finds dirty data, it raises a one-cycle push (copy-back) request that carries the snooped index. A read port lets the surrounding cache read any line's current state. Data storage, tag comparison and the bus protocol belong to other blocks.

States are `ST_INV`, `ST_EXC` and `ST_MOD`. Processor transitions:
- read miss: any state to `ST_EXC`, with a fill.
- write miss: any state to `ST_MOD`, with a fill.
- write hit: `ST_EXC` to `ST_MOD`.
- read hit or write hit on `ST_MOD`: stays `ST_MOD`.
- read hit on `ST_EXC`: stays `ST_EXC`.

Snoop transitions:
- cacheable read/write on `ST_MOD`: to `ST_INV`, with a push.
- cacheable read/write on `ST_EXC`: to `ST_INV`.
- inhibited read on `ST_EXC`: stays `ST_EXC`.
- inhibited read on `ST_MOD`: to `ST_EXC`, with a push.
- any snoop on `ST_INV`: no effect.

Top module: `mei_line_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, every line reads Invalid (state code 0), and `fill_req` and `push_req` are low.
- R2: A read miss (`proc_op`=1) leaves the line Exclusive (code 1). In the next cycle `fill_req` is high and `fill_idx` equals the line index.
- R3: A write miss (`proc_op`=3) leaves the line Modified (code 2) and raises a fill request in the same way as R2.
- R4: A write hit (`proc_op`=2) on an Exclusive line makes it Modified, with neither a fill nor a push request.
- R5: A read hit (`proc_op`=0) or write hit on a Modified line leaves it Modified, and a read hit on an Exclusive line leaves it Exclusive, with no request.
- R6: A cacheable snoop (`snp_cir`=0) on a Modified line makes it Invalid. In the next cycle `push_req` is high and `push_idx` equals the snooped index.
- R7: A cacheable snoop on an Exclusive line makes it Invalid with no push request.
- R8: A cache-inhibited snoop read (`snp_cir`=1) on an Exclusive line leaves it Exclusive with no push request.
- R9: A cache-inhibited snoop read on a Modified line requests a push and leaves the line Exclusive. Any snoop on an Invalid line has no effect and no request.
- R10: When a processor event and a snoop address the same line in one cycle, the snoop transition is applied first and the processor transition is applied to its result. A hit on a line that is Invalid at that point is treated as the miss of the same kind.
- R11: Processor and snoop events on different lines in the same cycle both take effect. Each request is high for exactly one cycle per event, and a request never appears without its event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| proc_valid | input | 1 | Processor event present |
| proc_op | input | 2 | 0 read hit, 1 read miss, 2 write hit, 3 write miss |
| proc_idx | input | IDX_W | Line addressed by the processor event |
| snp_valid | input | 1 | Snoop hit present |
| snp_cir | input | 1 | 1 cache-inhibited read, 0 cacheable read/write |
| snp_idx | input | IDX_W | Line addressed by the snoop |
| rd_idx | input | IDX_W | Line whose state is shown on rd_state |
| rd_state | output | 2 | Current state of line rd_idx (0 I, 1 E, 2 M) |
| fill_req | output | 1 | One-cycle cache block fill request |
| fill_idx | output | IDX_W | Line to fill |
| push_req | output | 1 | One-cycle snoop push request |
| push_idx | output | IDX_W | Line whose dirty data is pushed |

## Verification
The hardest case to reach is a snoop and a processor event on the same line in the same cycle. In that case the snoop must change the state the processor transition starts from, and both requests may fire together. The bench first drives the line to Modified. It then applies a read hit and a cacheable snoop to that line in one cycle, and expects a push, a fill and a final Exclusive state. It then pairs a write hit with an inhibited snoop on the now Exclusive line. Events on two different lines in one cycle are driven separately, so that the two write paths into the array are seen acting at once.

// File: rtl/mei_pkg.sv
package mei_pkg;

    typedef enum logic [1:0] {
        ST_INV = 2'd0,
        ST_EXC = 2'd1,
        ST_MOD = 2'd2
    } line_state_e;

    typedef enum logic [1:0] {
        OP_RD_HIT  = 2'd0,
        OP_RD_MISS = 2'd1,
        OP_WR_HIT  = 2'd2,
        OP_WR_MISS = 2'd3
    } proc_op_e;

endpackage

// File: rtl/mei_snoop_fsm.sv
module mei_snoop_fsm
    import mei_pkg::*;
(
    input  logic        valid_i,
    input  logic        inhibited_i,
    input  line_state_e cur_i,
    output line_state_e nxt_o,
    output logic        push_o
);

    always_comb begin
        nxt_o  = cur_i;
        push_o = 1'b0;
        if (valid_i) begin
            unique case (cur_i)
                ST_INV: nxt_o = ST_INV;
                ST_EXC: nxt_o = inhibited_i ? ST_EXC : ST_INV;
                ST_MOD: begin
                    push_o = 1'b1;
                    nxt_o  = inhibited_i ? ST_EXC : ST_INV;
                end
                default: nxt_o = ST_INV;
            endcase
        end
    end

endmodule

// File: rtl/mei_proc_fsm.sv
module mei_proc_fsm
    import mei_pkg::*;
(
    input  logic        valid_i,
    input  proc_op_e    op_i,
    input  line_state_e cur_i,
    output line_state_e nxt_o,
    output logic        fill_o
);

    always_comb begin
        nxt_o  = cur_i;
        fill_o = 1'b0;
        if (valid_i) begin
            unique case (op_i)
                OP_RD_MISS: begin
                    fill_o = 1'b1;
                    nxt_o  = ST_EXC;
                end
                OP_WR_MISS: begin
                    fill_o = 1'b1;
                    nxt_o  = ST_MOD;
                end
                OP_RD_HIT: begin
                    if (cur_i == ST_INV) begin
                        fill_o = 1'b1;
                        nxt_o  = ST_EXC;
                    end
                end
                OP_WR_HIT: begin
                    fill_o = (cur_i == ST_INV);
                    nxt_o  = ST_MOD;
                end
                default: nxt_o = cur_i;
            endcase
        end
    end

endmodule

// File: rtl/mei_line_array.sv
module mei_line_array
    import mei_pkg::*;
#(
    parameter int LINES = 16,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pri_en_i,
    input  logic [IDX_W-1:0]      pri_idx_i,
    input  line_state_e           pri_state_i,
    input  logic                  sec_en_i,
    input  logic [IDX_W-1:0]      sec_idx_i,
    input  line_state_e           sec_state_i,
    output logic [LINES-1:0][1:0] states_o
);

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic pri_sel, sec_sel;
        assign pri_sel = pri_en_i && (pri_idx_i == IDX_W'(g));
        assign sec_sel = sec_en_i && (sec_idx_i == IDX_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       states_o[g] <= ST_INV;
            else if (pri_sel) states_o[g] <= pri_state_i;
            else if (sec_sel) states_o[g] <= sec_state_i;
        end
    end

endmodule

// File: rtl/mei_line_ctrl.sv
module mei_line_ctrl
    import mei_pkg::*;
#(
    parameter int LINES = 16,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             proc_valid,
    input  logic [1:0]       proc_op,
    input  logic [IDX_W-1:0] proc_idx,
    input  logic             snp_valid,
    input  logic             snp_cir,
    input  logic [IDX_W-1:0] snp_idx,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [1:0]       rd_state,
    output logic             fill_req,
    output logic [IDX_W-1:0] fill_idx,
    output logic             push_req,
    output logic [IDX_W-1:0] push_idx
);

    logic [LINES-1:0][1:0] line_states;
    line_state_e snp_cur, snp_nxt, proc_cur, proc_nxt;
    logic        snp_push, proc_fill, same_line;

    assign snp_cur   = line_state_e'(line_states[snp_idx]);
    assign same_line = snp_valid && (snp_idx == proc_idx);
    // snoop result feeds the processor transition on a shared line
    assign proc_cur  = same_line ? snp_nxt : line_state_e'(line_states[proc_idx]);

    mei_snoop_fsm snoop_i (
        .valid_i     (snp_valid),
        .inhibited_i (snp_cir),
        .cur_i       (snp_cur),
        .nxt_o       (snp_nxt),
        .push_o      (snp_push)
    );

    mei_proc_fsm proc_i (
        .valid_i (proc_valid),
        .op_i    (proc_op_e'(proc_op)),
        .cur_i   (proc_cur),
        .nxt_o   (proc_nxt),
        .fill_o  (proc_fill)
    );

    mei_line_array #(.LINES(LINES)) array_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .pri_en_i    (proc_valid),
        .pri_idx_i   (proc_idx),
        .pri_state_i (proc_nxt),
        .sec_en_i    (snp_valid),
        .sec_idx_i   (snp_idx),
        .sec_state_i (snp_nxt),
        .states_o    (line_states)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_req <= 1'b0;
            fill_idx <= '0;
            push_req <= 1'b0;
            push_idx <= '0;
        end else begin
            fill_req <= proc_fill;
            fill_idx <= proc_idx;
            push_req <= snp_push;
            push_idx <= snp_idx;
        end
    end

    assign rd_state = line_states[rd_idx];

endmodule

module mei_line_ctrl_chk
    import mei_pkg::*;
#(
    parameter int LINES = 16,
    localparam int IDX_W = $clog2(LINES)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  proc_valid,
    input logic [1:0]            proc_op,
    input logic [IDX_W-1:0]      proc_idx,
    input logic                  snp_valid,
    input logic                  snp_cir,
    input logic [IDX_W-1:0]      snp_idx,
    input logic                  fill_req,
    input logic [IDX_W-1:0]      fill_idx,
    input logic                  push_req,
    input logic [IDX_W-1:0]      push_idx,
    input logic [LINES-1:0][1:0] line_states
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> (!fill_req && !push_req));

    // R2
    rd_miss_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_valid && proc_op == OP_RD_MISS)
        |=> (fill_req && fill_idx == $past(proc_idx)
             && line_states[$past(proc_idx)] == ST_EXC));

    // R3
    wr_miss_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_valid && proc_op == OP_WR_MISS)
        |=> (fill_req && line_states[$past(proc_idx)] == ST_MOD));

    // R4
    wr_hit_upgrade_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_valid && proc_op == OP_WR_HIT && line_states[proc_idx] == ST_EXC
         && !(snp_valid && snp_idx == proc_idx))
        |=> (!fill_req && line_states[$past(proc_idx)] == ST_MOD));

    // R6
    dirty_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && line_states[snp_idx] == ST_MOD)
        |=> (push_req && push_idx == $past(snp_idx)));

    // R7
    clean_no_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && line_states[snp_idx] != ST_MOD) |=> !push_req);

    // R11
    fill_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !proc_valid |=> !fill_req);

    // R11
    push_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !snp_valid |=> !push_req);

endmodule

bind mei_line_ctrl mei_line_ctrl_chk #(.LINES(LINES)) chk_i (.*);

// File: tb/mei_line_ctrl_tb.sv
module mei_line_ctrl_tb_top;

    localparam int LINES = 16;
    localparam int IDX_W = 4;
    localparam int NVEC  = 13;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             proc_valid = 1'b0;
    logic [1:0]       proc_op = '0;
    logic [IDX_W-1:0] proc_idx = '0;
    logic             snp_valid = 1'b0;
    logic             snp_cir = 1'b0;
    logic [IDX_W-1:0] snp_idx = '0;
    logic [IDX_W-1:0] rd_idx = '0;
    logic [1:0]       rd_state;
    logic             fill_req, push_req;
    logic [IDX_W-1:0] fill_idx, push_idx;

    int applied = 0;
    int misses  = 0;

    always #5 clk = ~clk;

    mei_line_ctrl #(.LINES(LINES)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .proc_valid(proc_valid), .proc_op(proc_op), .proc_idx(proc_idx),
        .snp_valid(snp_valid), .snp_cir(snp_cir), .snp_idx(snp_idx),
        .rd_idx(rd_idx), .rd_state(rd_state),
        .fill_req(fill_req), .fill_idx(fill_idx),
        .push_req(push_req), .push_idx(push_idx)
    );

    // vector: req4 pv1 op2 pidx4 sv1 cir1 sidx4 cidx4 est2 efill1 epush1
    function automatic logic [24:0] mkv(int req, bit pv, int op, int pidx, bit sv, bit cir,
                                        int sidx, int cidx, int est, bit ef, bit ep);
        return {4'(req), pv, 2'(op), 4'(pidx), sv, cir, 4'(sidx), 4'(cidx), 2'(est), ef, ep};
    endfunction

    localparam logic [24:0] VECS [NVEC] = '{
        mkv(2,  1, 1, 1, 0, 0, 0, 1, 1, 1, 0),  // R2 read miss line 1
        mkv(5,  1, 0, 1, 0, 0, 0, 1, 1, 0, 0),  // R5 read hit on E
        mkv(4,  1, 2, 1, 0, 0, 0, 1, 2, 0, 0),  // R4 write hit E->M
        mkv(5,  1, 2, 1, 0, 0, 0, 1, 2, 0, 0),  // R5 write hit on M
        mkv(5,  1, 0, 1, 0, 0, 0, 1, 2, 0, 0),  // R5 read hit on M
        mkv(6,  0, 0, 0, 1, 0, 1, 1, 0, 0, 1),  // R6 cacheable snoop on M
        mkv(3,  1, 3, 2, 0, 0, 0, 2, 2, 1, 0),  // R3 write miss line 2
        mkv(2,  1, 1, 3, 0, 0, 0, 3, 1, 1, 0),  // R2 read miss line 3
        mkv(8,  0, 0, 0, 1, 1, 3, 3, 1, 0, 0),  // R8 inhibited snoop on E
        mkv(7,  0, 0, 0, 1, 0, 3, 3, 0, 0, 0),  // R7 cacheable snoop on E
        mkv(9,  0, 0, 0, 1, 0, 3, 3, 0, 0, 0),  // R9 snoop on Invalid
        mkv(9,  0, 0, 0, 1, 1, 2, 2, 1, 0, 1),  // R9 inhibited snoop on M
        mkv(11, 1, 1, 4, 1, 0, 2, 4, 1, 1, 0)   // R11 two lines at once
    };

    task automatic check(string tag, int act, int exp);
        applied++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic drive(bit pv, int op, int pidx, bit sv, bit cir, int sidx);
        @(negedge clk);
        proc_valid = pv; proc_op = 2'(op); proc_idx = 4'(pidx);
        snp_valid = sv;  snp_cir = cir;    snp_idx = 4'(sidx);
        @(posedge clk);
        #1;
        proc_valid = 1'b0; snp_valid = 1'b0;
    endtask

    task automatic read_state(int idx, output int st);
        rd_idx = 4'(idx);
        #1;
        st = int'(rd_state);
    endtask

    initial begin
        repeat (10000) @(posedge clk);
        misses++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("== %0d vectors applied, %0d miscompares ==", applied, misses);
        $finish;
    end

    initial begin
        int st;
        repeat (3) @(posedge clk);
        #1;
        check("R1 fill in reset", int'(fill_req), 0);
        check("R1 push in reset", int'(push_req), 0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < LINES; i++) begin
            read_state(i, st);
            check("R1 line after reset", st, 0);
        end

        for (int v = 0; v < NVEC; v++) begin
            logic [24:0] w;
            string tag;
            w = VECS[v];
            tag = $sformatf("R%0d vec %0d", int'(w[24:21]), v);
            drive(w[20], int'(w[19:18]), int'(w[17:14]), w[13], w[12], int'(w[11:8]));
            read_state(int'(w[7:4]), st);
            check({tag, " state"}, st, int'(w[3:2]));
            check({tag, " fill"}, int'(fill_req), int'(w[1]));
            check({tag, " push"}, int'(push_req), int'(w[0]));
            if (w[1]) check({tag, " fill_idx"}, int'(fill_idx), int'(w[17:14]));
            if (w[0]) check({tag, " push_idx"}, int'(push_idx), int'(w[11:8]));
        end
        // R11: snooped line of the last vector also changed
        read_state(2, st);
        check("R11 second line", st, 0);

        // R10: same line, read hit with cacheable snoop on a Modified line
        drive(1, 3, 6, 0, 0, 0);
        drive(1, 0, 6, 1, 0, 6);
        read_state(6, st);
        check("R10 same-line state", st, 1);
        check("R10 same-line fill", int'(fill_req), 1);
        check("R10 same-line push", int'(push_req), 1);
        check("R10 push_idx", int'(push_idx), 6);
        // R10: write hit with inhibited snoop on an Exclusive line
        drive(1, 2, 6, 1, 1, 6);
        read_state(6, st);
        check("R10 hit after CIR state", st, 2);
        check("R10 hit after CIR fill", int'(fill_req), 0);
        check("R10 hit after CIR push", int'(push_req), 0);

        // R11: pulses last one cycle
        drive(0, 0, 0, 0, 0, 0);
        check("R11 fill drops", int'(fill_req), 0);
        check("R11 push drops", int'(push_req), 0);

        // R1: reset in mid-run clears lines
        drive(1, 1, 9, 1, 1, 6);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        read_state(6, st);
        check("R1 mid reset line 6", st, 0);
        read_state(9, st);
        check("R1 mid reset line 9", st, 0);
        check("R1 mid reset fill", int'(fill_req), 0);
        check("R1 mid reset push", int'(push_req), 0);

        $display("== %0d vectors applied, %0d miscompares ==", applied, misses);
        $finish;
    end

endmodule